// File: doc/BRIEF.md
# Overlapped Fetch-Execute Cycle Sequencer

This block sequences the bus cycles of a minimal 8-bit processor core with a 16-bit address. It counts whole clock cycles, one per edge, in a one-hot timing register that runs from one opcode fetch to the next. In every cycle it puts an address on the bus and marks opcode fetches with a sync output. It captures bus bytes into an opcode holding register, an instruction register, an input data latch and an adder hold register.

Three instruction kinds exist. The first is a two-cycle no-operation, which also covers every unrecognised opcode. The second is a two-cycle decrement of the index register. The third is a four-cycle accumulator load from an absolute address. The second cycle of every instruction reads the byte after the opcode, because decode cannot act sooner. The register write of an instruction is deferred: it happens at the end of the next instruction's opcode fetch cycle, overlapping that fetch. A low ready input freezes the whole sequencer.

Top module: `seq_core`

## Requirements
- R1: While reset is held at a clock edge, the program counter is loaded with the RESET_PC parameter (default 16'hF000) and the timing register enters the fetch state. After that edge, addr equals RESET_PC, sync is 1, rd_n_wr is 1, and acc and xreg are 8'h00.
- R2: In an opcode fetch cycle, sync is 1 and addr is the program counter. In all other cycles sync is 0.
- R3: The cycle after every opcode fetch reads the address one past the opcode, whatever the opcode is.
- R4: Opcode 8'h00 and every opcode other than 8'hA1 and 8'hD1 take two cycles. The next fetch uses the opcode address plus 1, so the second-cycle increment is discarded.
- R5: Opcode 8'hD1 takes two cycles and its next fetch is at opcode address plus 1. xreg becomes xreg minus 1 (mod 256) at the end of the following opcode fetch cycle, not earlier.
- R6: Opcode 8'hA1 takes four cycles. Cycles 2 and 3 read opcode+1 (low byte) and opcode+2 (high byte). Cycle 4 reads {high byte, low byte} without advancing the program counter. The next fetch is at opcode+3.
- R7: The byte read in cycle 4 of 8'hA1 reaches acc at the end of the following opcode fetch cycle, and acc is unchanged before that.
- R8: While rdy is 0 at a clock edge, addr, sync, the timing state, acc and xreg keep their values, and the data bus byte is not captured.
- R9: Exactly one timing-state bit is set at all times after reset.
- R10: rd_n_wr is always 1 (read), since this block performs no stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdy | input | 1 | Ready; 0 stalls the sequencer |
| data_in | input | 8 | Data bus byte read in the current cycle |
| addr | output | 16 | Address bus |
| rd_n_wr | output | 1 | 1 = read cycle |
| sync | output | 1 | 1 during an opcode fetch cycle |
| acc | output | 8 | Accumulator |
| xreg | output | 8 | Index register |

## Verification
Address and sync follow from the registered state, so each is due in the cycle right after the edge that advanced the sequencer. The decrement and load results show up one edge after the end of the next opcode fetch. For a load, that is five edges after the load's own fetch edge, counting from the fetch edge itself. The bench keeps a behavioural model that it steps once per edge, using the same ready value the design sees. It compares every output half a cycle after each edge, so stalls shift the model and the design by the same amount.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [7:0] OPC_NOP  = 8'h00;
  localparam logic [7:0] OPC_DECX = 8'hD1;
  localparam logic [7:0] OPC_LOAD = 8'hA1;

  localparam int TS_N     = 4;
  localparam int TS_FETCH = 0;
  localparam int TS_OPND  = 1;
  localparam int TS_HIGH  = 2;
  localparam int TS_DATA  = 3;
endpackage

// File: rtl/seq_tstate.sv
module seq_tstate #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         wrap,
  output logic [N-1:0] q
);
  localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] shifted;

  generate
    if (N > 1) begin : g_shift
      assign shifted = {q[N-2:0], 1'b0};
    end else begin : g_single
      assign shifted = FIRST;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      q <= FIRST;
    else if (adv)
      q <= wrap ? FIRST : shifted;
  end
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int          AW       = 16,
  parameter logic [15:0] RESET_PC = 16'hF000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          step,
  output logic [AW-1:0] pc
);
  function automatic logic [AW-1:0] f_inc(input logic [AW-1:0] v);
    return v + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)
      pc <= AW'(RESET_PC);
    else if (en && step)
      pc <= f_inc(pc);
  end
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] data_in,
  input  logic          cap_pd,
  input  logic          cap_ir,
  input  logic          cap_idl,
  input  logic          cap_ahr,
  input  logic          commit_ld,
  input  logic          commit_dec,
  output logic [DW-1:0] pd,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] idl,
  output logic [DW-1:0] ahr,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] xr
);
  function automatic logic [DW-1:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      pd  <= '0;
      ir  <= '0;
      idl <= '0;
      ahr <= '0;
      acc <= '0;
      xr  <= '0;
    end else if (en) begin
      if (cap_pd)     pd  <= data_in;
      if (cap_ir)     ir  <= pd;
      if (cap_idl)    idl <= data_in;
      if (cap_ahr)    ahr <= f_add(idl, '0);
      if (commit_ld)  acc <= idl;
      if (commit_dec) xr  <= f_add(xr, '1);
    end
  end
endmodule

// File: rtl/seq_core.sv
module seq_core #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] RESET_PC = 16'hF000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rdy,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr,
  output logic          rd_n_wr,
  output logic          sync,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] xreg
);
  import seq_pkg::*;

  localparam int HW = AW - DW;

  logic [TS_N-1:0] tstate;
  logic [AW-1:0]   pc;
  logic [DW-1:0]   pd, ir, idl, ahr;
  logic            pend_ld, pend_dec;

  // named internal events
  logic t_fetch, t_opnd, t_high, t_data;
  logic ld_pd, ld_ir, dec_pd;
  logic wrap, pc_step, commit_ld, commit_dec;

  assign t_fetch = tstate[TS_FETCH];
  assign t_opnd  = tstate[TS_OPND];
  assign t_high  = tstate[TS_HIGH];
  assign t_data  = tstate[TS_DATA];

  assign ld_pd  = (pd == OPC_LOAD);
  assign dec_pd = (pd == OPC_DECX);
  assign ld_ir  = (ir == OPC_LOAD);

  assign wrap       = (t_opnd && !ld_pd) || t_data;
  assign pc_step    = t_fetch || (t_opnd && ld_pd) || (t_high && ld_ir);
  assign commit_ld  = t_fetch && pend_ld;
  assign commit_dec = t_fetch && pend_dec;

  seq_tstate #(.N(TS_N)) u_tstate (
    .clk (clk), .rst (rst), .adv (rdy), .wrap (wrap), .q (tstate)
  );

  seq_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk (clk), .rst (rst), .en (rdy), .step (pc_step), .pc (pc)
  );

  seq_dpath #(.DW(DW)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .en         (rdy),
    .data_in    (data_in),
    .cap_pd     (t_fetch),
    .cap_ir     (t_opnd),
    .cap_idl    (t_opnd || t_high || t_data),
    .cap_ahr    (t_high && ld_ir),
    .commit_ld  (commit_ld),
    .commit_dec (commit_dec),
    .pd         (pd),
    .ir         (ir),
    .idl        (idl),
    .ahr        (ahr),
    .acc        (acc),
    .xr         (xreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ld  <= 1'b0;
      pend_dec <= 1'b0;
    end else if (rdy) begin
      if (t_fetch) begin
        pend_ld  <= 1'b0;
        pend_dec <= 1'b0;
      end
      if (t_opnd) pend_dec <= dec_pd;
      if (t_data) pend_ld  <= 1'b1;
    end
  end

  assign addr    = t_data ? {idl[HW-1:0], ahr} : pc;
  assign sync    = t_fetch;
  assign rd_n_wr = 1'b1;
endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rdy,
  input logic [AW-1:0] addr,
  input logic          sync,
  input logic          rd_n_wr,
  input logic [DW-1:0] acc,
  input logic [3:0]    tstate,
  input logic [DW-1:0] pd,
  input logic          pc_step,
  input logic          commit_ld
);
  // R9
  onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tstate) == 1);

  // R2
  sync_marks_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    sync == tstate[0]);

  // R3
  fetch_then_opnd_chk: assert property (@(posedge clk) disable iff (rst)
    (tstate[0] && rdy) |=> tstate[1]);

  // R4
  short_op_refetch_chk: assert property (@(posedge clk) disable iff (rst)
    (tstate[1] && rdy && pd != 8'hA1) |=> (sync && addr == $past(addr)));

  // R6
  data_cycle_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    tstate[3] |-> !pc_step);

  // R7
  load_commit_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    commit_ld |-> sync);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> ($stable(addr) && $stable(sync) && $stable(tstate) && $stable(acc)));

  // R10
  read_only_chk: assert property (@(posedge clk) disable iff (rst)
    rd_n_wr);
endmodule

bind seq_core seq_core_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .rdy       (rdy),
  .addr      (addr),
  .sync      (sync),
  .rd_n_wr   (rd_n_wr),
  .acc       (acc),
  .tstate    (tstate),
  .pd        (pd),
  .pc_step   (pc_step),
  .commit_ld (commit_ld)
);

// File: tb/test_seq_core.sv
`timescale 1ns/1ps
module test_seq_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdy = 1'b1;
  logic [7:0]  data_in;
  logic [15:0] addr;
  logic        rd_n_wr, sync;
  logic [7:0]  acc, xreg;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  seq_core i_seq_core (
    .clk (clk), .rst (rst), .rdy (rdy), .data_in (data_in),
    .addr (addr), .rd_n_wr (rd_n_wr), .sync (sync), .acc (acc), .xreg (xreg)
  );

  // memory image: short program at 16'hF000, NOPs after it, hashed bytes elsewhere
  function automatic logic [7:0] mem(input logic [15:0] a);
    if (a >= 16'hF000 && a < 16'hF00E) begin
      case (a[3:0])
        4'd0:  return 8'hD1;
        4'd1:  return 8'hA1;
        4'd2:  return 8'h34;
        4'd3:  return 8'h12;
        4'd4:  return 8'h00;
        4'd5:  return 8'h77;
        4'd6:  return 8'hA1;
        4'd7:  return 8'hFF;
        4'd8:  return 8'h20;
        4'd9:  return 8'hD1;
        4'd10: return 8'hD1;
        4'd11: return 8'hA1;
        4'd12: return 8'h00;
        default: return 8'hF0;
      endcase
    end else if (a >= 16'hF000) begin
      return 8'h00;
    end
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign data_in = rdy ? mem(addr) : 8'hEE;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          ph;
  logic [15:0] m_pc;
  logic [7:0]  m_op, m_lo, m_idl, m_acc, m_x;
  bit          m_pld, m_pdec, m_valid, m_stalled, m_first;
  int          m_last; // 0 short op, 1 decrement, 2 load

  function automatic logic [15:0] exp_addr();
    return (ph == 3) ? {m_idl, m_lo} : m_pc;
  endfunction

  task automatic model_step(input bit r, input bit go);
    logic [7:0] d;
    if (r) begin
      ph = 0; m_pc = 16'hF000; m_acc = 0; m_x = 0; m_idl = 0; m_lo = 0; m_op = 0;
      m_pld = 0; m_pdec = 0; m_valid = 1; m_first = 1; m_stalled = 0; m_last = 0;
      return;
    end
    m_stalled = !go;
    if (!go) return;
    d = mem(exp_addr());
    m_first = 0;
    case (ph)
      0: begin
        m_op = d;
        if (m_pld)  m_acc = m_idl;
        if (m_pdec) m_x = m_x - 8'd1;
        m_pld = 0; m_pdec = 0;
        m_pc = m_pc + 16'd1;
        ph = 1;
      end
      1: begin
        m_idl = d;
        if (m_op == 8'hA1) begin
          m_pc = m_pc + 16'd1;
          ph = 2;
        end else begin
          m_pdec = (m_op == 8'hD1);
          m_last = m_pdec ? 1 : 0;
          ph = 0;
        end
      end
      2: begin
        m_lo = m_idl;
        m_idl = d;
        m_pc = m_pc + 16'd1;
        ph = 3;
      end
      default: begin
        m_idl = d;
        m_pld = 1;
        m_last = 2;
        ph = 0;
      end
    endcase
  endtask

  task automatic compare();
    string ta, ts;
    if (m_first)        ta = "R1 addr";
    else if (m_stalled) ta = "R8 addr";
    else if (ph == 1)   ta = "R3 addr";
    else if (ph >= 2)   ta = "R6 addr";
    else if (m_last == 2) ta = "R6 next fetch addr";
    else if (m_last == 1) ta = "R5 next fetch addr";
    else                ta = "R4 next fetch addr";
    ts = (ph == 0) ? "R2 sync" : "R9 sync";
    chk(addr === exp_addr(), ta, addr, exp_addr());
    chk(sync === (ph == 0), ts, sync, (ph == 0));
    chk(rd_n_wr === 1'b1, "R10 rd_n_wr", rd_n_wr, 1);
    chk(acc === m_acc, m_first ? "R1 acc" : "R7 acc", acc, m_acc);
    chk(xreg === m_x, m_first ? "R1 xreg" : "R5 xreg", xreg, m_x);
  endtask

  initial begin
    m_valid = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      if (m_valid) compare();
      rst = (cyc < 3);
      rdy = !(cyc > 30 && (cyc % 13 == 4 || cyc % 13 == 5));
      model_step(rst, rdy);
    end
    // R7 / R5 end-state sanity: three loads and three decrements have landed
    chk(acc === 8'hD1, "R7 final acc", acc, 8'hD1);
    chk(xreg === 8'hFD, "R5 final xreg", xreg, 8'hFD);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule